// File: doc/BRIEF.md
# Dual-Pixel Data-Enable Raster Generator

This block produces the raster timing for a full-HD panel that receives two pixels on every clock and uses only a data-enable strobe. A horizontal counter and a vertical counter walk a frame of programmable size. The active window is fixed at 960 pixel-pair clocks by 1080 lines. The horizontal and vertical blanking lengths come from configuration inputs. Each requested length is checked against its legal range, and an illegal value is replaced by the default.

During the active window the block asks an upstream source for one 48-bit pixel pair per clock through a ready/valid handshake. It places the pair on two 24-bit RGB buses. The odd bus carries the first pixel of each pair, so the first pixel of every frame and line lands on the odd bus.

A 50/60 Hz mode input stretches the vertical total for 50 Hz operation. The block also checks each frame's length in clocks against the legal frame-rate window for the selected mode. If the upstream source runs dry in the middle of a line, the block keeps the timing running, sends black and sets a sticky error flag.

Top module: `dual_pixel_raster`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `de` is low, both RGB buses are zero, and `underflow_err` and `rate_err` are low. The first frame begins at the first rising edge after reset is released, and `de` is first high after the second rising edge.
- R2: On every active line, `de` is high for exactly H_ACT consecutive clocks. Successive lines start H_ACT + hblank clocks apart.
- R3: Each frame holds exactly V_ACT lines with `de` high. When `mode_50hz` is 0, the frame lasts (H_ACT + hblank) × (V_ACT + vblank) clocks. When `mode_50hz` is 1, the vertical total gains (V_ACT + VB_DEF) × 10 / 50 extra lines (integer division).
- R4: An `hblank_cfg` value outside [HB_MIN, HB_MAX] is replaced by HB_DEF. A `vblank_cfg` value outside [VB_MIN, VB_MAX] is replaced by VB_DEF.
- R5: `hblank_cfg`, `vblank_cfg` and `mode_50hz` are sampled only at the edge where a frame starts. A change in the middle of a frame leaves that frame's length unchanged.
- R6: `pix_ready` is high exactly on active clocks.
  - A pair taken on an edge with `pix_ready` and `pix_valid` both high appears on the buses after that edge, with `de` high.
  - Bits 47:24 go to `odd_rgb` (the first pixel) and bits 23:0 go to `even_rgb`. Each pixel is R in 23:16, G in 15:8 and B in 7:0.
  - One pair is consumed per `de` clock, and both buses are zero while `de` is low.
- R7: An active clock with `pix_valid` low still gives `de` high, but both buses are zero. It sets `underflow_err`, which stays high until reset.
- R8: `rate_err` is updated at each frame start and stays fixed for that frame. It is high when the frame length in clocks lies outside [CLK_HZ/63, CLK_HZ/57] in 60 Hz mode, or outside [CLK_HZ/53, CLK_HZ/47] in 50 Hz mode (integer division).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-pair clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_50hz | input | 1 | 1 selects the stretched 50 Hz vertical total |
| hblank_cfg | input | CFG_W | Requested horizontal blanking, in clocks |
| vblank_cfg | input | CFG_W | Requested vertical blanking, in lines |
| pix_valid | input | 1 | Upstream pair available |
| pix_data | input | 48 | Pixel pair; first pixel in 47:24 |
| pix_ready | output | 1 | Block takes a pair this clock |
| de | output | 1 | Data enable, high for active pixels |
| odd_rgb | output | 24 | First pixel of the pair, RGB888 |
| even_rgb | output | 24 | Second pixel of the pair, RGB888 |
| underflow_err | output | 1 | Sticky flag for a missing pair during active video |
| rate_err | output | 1 | Current frame's length is outside the mode's rate window |

## Verification
The bench steps through blanking settings and modes that land exactly on the lower edge of the rate window, just outside it on both sides, and out of range for fallback. A design that ignored the fallback, picked the wrong 50 Hz stretch or got a window bound wrong would show a wrong frame length or a wrong `rate_err`. It changes settings in the middle of a frame and expects that frame to keep its old length, which catches a design that samples the configuration on every clock. Holding `pix_valid` low during a line shows whether the design stalls the raster or leaks stale pixels instead of sending black. A reset afterwards shows whether the error flag is really sticky until reset.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int RGB_W  = 24;
  localparam int PAIR_W = 2 * RGB_W;

  typedef logic [RGB_W-1:0] rgb_t;

  // extra lines that bring a frame sized for rate_hi down to rate_lo
  function automatic int stretch_lines(input int vtot, input int rate_hi, input int rate_lo);
    return vtot * (rate_hi - rate_lo) / rate_lo;
  endfunction
endpackage

// File: rtl/dpr_cfg_guard.sv
module dpr_cfg_guard #(
  parameter int H_ACT   = 960,
  parameter int V_ACT   = 1080,
  parameter int HB_MIN  = 90,
  parameter int HB_MAX  = 190,
  parameter int HB_DEF  = 140,
  parameter int VB_MIN  = 35,
  parameter int VB_MAX  = 55,
  parameter int VB_DEF  = 45,
  parameter int V_EXT50 = 225,
  parameter int CFG_W   = 8,
  parameter int HTW     = 11,
  parameter int VTW     = 11,
  parameter int CLK_HZ  = 74_250_000,
  parameter int R60_LO  = 57,
  parameter int R60_HI  = 63,
  parameter int R50_LO  = 47,
  parameter int R50_HI  = 53
) (
  input  logic [CFG_W-1:0] hblank_cfg,
  input  logic [CFG_W-1:0] vblank_cfg,
  input  logic             mode_50hz,
  output logic [CFG_W-1:0] hb_eff,
  output logic [CFG_W-1:0] vb_eff,
  output logic             rate_bad
);
  localparam int FLW = HTW + VTW;
  localparam logic [FLW-1:0] LEN60_MIN = FLW'(CLK_HZ / R60_HI);
  localparam logic [FLW-1:0] LEN60_MAX = FLW'(CLK_HZ / R60_LO);
  localparam logic [FLW-1:0] LEN50_MIN = FLW'(CLK_HZ / R50_HI);
  localparam logic [FLW-1:0] LEN50_MAX = FLW'(CLK_HZ / R50_LO);

  logic [HTW-1:0] htot_n;
  logic [VTW-1:0] vtot_n;
  logic [FLW-1:0] flen_n;

  always_comb begin
    hb_eff = (hblank_cfg < CFG_W'(HB_MIN) || hblank_cfg > CFG_W'(HB_MAX)) ? CFG_W'(HB_DEF) : hblank_cfg;
    vb_eff = (vblank_cfg < CFG_W'(VB_MIN) || vblank_cfg > CFG_W'(VB_MAX)) ? CFG_W'(VB_DEF) : vblank_cfg;
    htot_n = HTW'(H_ACT) + HTW'(hb_eff);
    vtot_n = VTW'(V_ACT) + VTW'(vb_eff) + (mode_50hz ? VTW'(V_EXT50) : '0);
    flen_n = FLW'(htot_n) * FLW'(vtot_n);
    if (mode_50hz) rate_bad = (flen_n < LEN50_MIN) || (flen_n > LEN50_MAX);
    else           rate_bad = (flen_n < LEN60_MIN) || (flen_n > LEN60_MAX);
  end
endmodule

// File: rtl/dpr_raster.sv
module dpr_raster #(
  parameter int H_ACT   = 960,
  parameter int V_ACT   = 1080,
  parameter int HB_MIN  = 90,
  parameter int HB_MAX  = 190,
  parameter int HB_DEF  = 140,
  parameter int VB_MIN  = 35,
  parameter int VB_MAX  = 55,
  parameter int VB_DEF  = 45,
  parameter int V_EXT50 = 225,
  parameter int CFG_W   = 8,
  parameter int HTW     = 11,
  parameter int VTW     = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] hb_eff,
  input  logic [CFG_W-1:0] vb_eff,
  input  logic             mode_50hz,
  input  logic             rate_bad,
  output logic             act,
  output logic             rate_err
);
  logic [HTW-1:0]   hcnt, htot;
  logic [VTW-1:0]   vcnt, vtot;
  logic [CFG_W-1:0] hb_l, vb_l;
  logic             m50_l, started;
  logic             line_end, frame_end;

  always_comb begin
    htot      = HTW'(H_ACT) + HTW'(hb_l);
    vtot      = VTW'(V_ACT) + VTW'(vb_l) + (m50_l ? VTW'(V_EXT50) : '0);
    line_end  = (hcnt == htot - HTW'(1));
    frame_end = line_end && (vcnt == vtot - VTW'(1));
    act       = started && (hcnt < HTW'(H_ACT)) && (vcnt < VTW'(V_ACT));
  end

  // reset parks the counters on the last clock of a default frame, so the
  // first edge after release opens a complete frame
  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt     <= HTW'(H_ACT + HB_DEF - 1);
      vcnt     <= VTW'(V_ACT + VB_DEF - 1);
      hb_l     <= CFG_W'(HB_DEF);
      vb_l     <= CFG_W'(VB_DEF);
      m50_l    <= 1'b0;
      started  <= 1'b0;
      rate_err <= 1'b0;
    end else if (frame_end) begin
      hcnt     <= '0;
      vcnt     <= '0;
      hb_l     <= hb_eff;
      vb_l     <= vb_eff;
      m50_l    <= mode_50hz;
      started  <= 1'b1;
      rate_err <= rate_bad;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= vcnt + VTW'(1);
    end else begin
      hcnt <= hcnt + HTW'(1);
    end
  end

  AST_HCNT_IN_LINE: assert property (@(posedge clk) disable iff (rst)
    (hcnt < htot) && (vcnt < vtot)); // R2
  AST_FIRST_FRAME_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    $rose(started) |-> (hcnt == '0) && (vcnt == '0)); // R1
  AST_CFG_HELD_MIDFRAME: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(hb_l) && $stable(vb_l) && $stable(m50_l) && $stable(rate_err)); // R5
  AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (hb_l >= CFG_W'(HB_MIN)) && (hb_l <= CFG_W'(HB_MAX)) &&
    (vb_l >= CFG_W'(VB_MIN)) && (vb_l <= CFG_W'(VB_MAX))); // R4
endmodule

// File: rtl/dpr_pix_out.sv
module dpr_pix_out
  import dpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  logic              pix_valid,
  input  logic [PAIR_W-1:0] pix_data,
  output logic              pix_ready,
  output logic              de,
  output rgb_t              odd_rgb,
  output rgb_t              even_rgb,
  output logic              underflow_err
);
  assign pix_ready = act;

  always_ff @(posedge clk) begin
    if (rst) begin
      de            <= 1'b0;
      odd_rgb       <= '0;
      even_rgb      <= '0;
      underflow_err <= 1'b0;
    end else begin
      de <= act;
      if (act && pix_valid) begin
        odd_rgb  <= pix_data[PAIR_W-1 -: RGB_W];
        even_rgb <= pix_data[RGB_W-1:0];
      end else begin
        odd_rgb  <= '0;
        even_rgb <= '0;
      end
      if (act && !pix_valid) underflow_err <= 1'b1;
    end
  end

  AST_BLACK_ON_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    act && !pix_valid |=> de && (odd_rgb == '0) && (even_rgb == '0) && underflow_err); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    underflow_err |=> underflow_err); // R7
  AST_QUIET_BLANK: assert property (@(posedge clk) disable iff (rst)
    !de |-> (odd_rgb == '0) && (even_rgb == '0)); // R6
  AST_PAIR_PASSES: assert property (@(posedge clk) disable iff (rst)
    act && pix_valid |=> de && (odd_rgb == $past(pix_data[PAIR_W-1 -: RGB_W])) &&
                         (even_rgb == $past(pix_data[RGB_W-1:0]))); // R6
endmodule

// File: rtl/dual_pixel_raster.sv
module dual_pixel_raster
  import dpr_pkg::*;
#(
  parameter int H_ACT  = 960,
  parameter int V_ACT  = 1080,
  parameter int HB_MIN = 90,
  parameter int HB_MAX = 190,
  parameter int HB_DEF = 140,
  parameter int VB_MIN = 35,
  parameter int VB_MAX = 55,
  parameter int VB_DEF = 45,
  parameter int CFG_W  = 8,
  parameter int CLK_HZ = 74_250_000,
  parameter int NOM60  = 60,
  parameter int NOM50  = 50,
  parameter int R60_LO = 57,
  parameter int R60_HI = 63,
  parameter int R50_LO = 47,
  parameter int R50_HI = 53
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_50hz,
  input  logic [CFG_W-1:0]  hblank_cfg,
  input  logic [CFG_W-1:0]  vblank_cfg,
  input  logic              pix_valid,
  input  logic [47:0]       pix_data,
  output logic              pix_ready,
  output logic              de,
  output logic [23:0]       odd_rgb,
  output logic [23:0]       even_rgb,
  output logic              underflow_err,
  output logic              rate_err
);
  localparam int V_EXT50  = stretch_lines(V_ACT + VB_DEF, NOM60, NOM50);
  localparam int HTOT_MAX = H_ACT + HB_MAX;
  localparam int VTOT_MAX = V_ACT + VB_MAX + V_EXT50;
  localparam int HTW      = $clog2(HTOT_MAX + 1);
  localparam int VTW      = $clog2(VTOT_MAX + 1);

  logic [CFG_W-1:0] hb_eff, vb_eff;
  logic             rate_bad, act;

  dpr_cfg_guard #(
    .H_ACT(H_ACT), .V_ACT(V_ACT),
    .HB_MIN(HB_MIN), .HB_MAX(HB_MAX), .HB_DEF(HB_DEF),
    .VB_MIN(VB_MIN), .VB_MAX(VB_MAX), .VB_DEF(VB_DEF),
    .V_EXT50(V_EXT50), .CFG_W(CFG_W), .HTW(HTW), .VTW(VTW),
    .CLK_HZ(CLK_HZ), .R60_LO(R60_LO), .R60_HI(R60_HI),
    .R50_LO(R50_LO), .R50_HI(R50_HI)
  ) u_guard (
    .hblank_cfg(hblank_cfg), .vblank_cfg(vblank_cfg), .mode_50hz(mode_50hz),
    .hb_eff(hb_eff), .vb_eff(vb_eff), .rate_bad(rate_bad)
  );

  dpr_raster #(
    .H_ACT(H_ACT), .V_ACT(V_ACT),
    .HB_MIN(HB_MIN), .HB_MAX(HB_MAX), .HB_DEF(HB_DEF),
    .VB_MIN(VB_MIN), .VB_MAX(VB_MAX), .VB_DEF(VB_DEF),
    .V_EXT50(V_EXT50), .CFG_W(CFG_W), .HTW(HTW), .VTW(VTW)
  ) u_raster (
    .clk(clk), .rst(rst), .hb_eff(hb_eff), .vb_eff(vb_eff),
    .mode_50hz(mode_50hz), .rate_bad(rate_bad), .act(act), .rate_err(rate_err)
  );

  dpr_pix_out u_pix (
    .clk(clk), .rst(rst), .act(act), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready), .de(de), .odd_rgb(odd_rgb), .even_rgb(even_rgb),
    .underflow_err(underflow_err)
  );
endmodule

// File: tb/dual_pixel_raster_test.sv
module dual_pixel_raster_test;
  localparam int H_ACT = 4, V_ACT = 3;
  localparam int HB_MIN = 2, HB_MAX = 5, HB_DEF = 3;
  localparam int VB_MIN = 2, VB_MAX = 4, VB_DEF = 3;
  localparam int CLK_HZ = 2520;
  localparam int T_CLK = 20;
  localparam int NVEC = 10;
  // hblank, vblank, mode_50hz, expected line period, expected frame length, expected rate_err
  localparam int VEC [NVEC][6] = '{
    '{2, 2, 0, 6, 30, 1},
    '{5, 4, 0, 9, 63, 1},
    '{1, 3, 0, 7, 42, 0},
    '{9, 7, 0, 7, 42, 0},
    '{4, 2, 0, 8, 40, 0},
    '{3, 4, 0, 7, 49, 1},
    '{3, 3, 1, 7, 49, 0},
    '{5, 4, 1, 9, 72, 1},
    '{2, 2, 1, 6, 36, 1},
    '{2, 4, 1, 6, 48, 0}
  };

  logic clk = 0, rst = 1, mode_50hz = 0, pix_valid = 1;
  logic [7:0] hblank_cfg = 8'(HB_DEF), vblank_cfg = 8'(VB_DEF);
  logic [47:0] pix_data;
  logic pix_ready, de, underflow_err, rate_err;
  logic [23:0] odd_rgb, even_rgb;
  int k = 0, checks = 0, fails = 0, pix_bad = 0;
  int bad_act = 0, bad_exp = 0;
  bit mon_en = 0;

  always #(T_CLK/2) clk = ~clk;

  assign pix_data = {24'(2 * k), 24'(2 * k + 1)};

  always @(posedge clk) begin
    if (rst) k <= 0;
    else if (pix_ready && pix_valid) k <= k + 1;
  end

  // pair taken on the last edge is index k-1
  always @(negedge clk) begin
    if (mon_en && !rst && de) begin
      if (odd_rgb !== 24'(2 * (k - 1)) || even_rgb !== 24'(2 * (k - 1) + 1)) begin
        pix_bad++;
        bad_act = int'(odd_rgb);
        bad_exp = 2 * (k - 1);
      end
    end
  end

  dual_pixel_raster #(
    .H_ACT(H_ACT), .V_ACT(V_ACT),
    .HB_MIN(HB_MIN), .HB_MAX(HB_MAX), .HB_DEF(HB_DEF),
    .VB_MIN(VB_MIN), .VB_MAX(VB_MAX), .VB_DEF(VB_DEF),
    .CFG_W(8), .CLK_HZ(CLK_HZ)
  ) uut (
    .clk(clk), .rst(rst), .mode_50hz(mode_50hz), .hblank_cfg(hblank_cfg),
    .vblank_cfg(vblank_cfg), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready), .de(de), .odd_rgb(odd_rgb), .even_rgb(even_rgb),
    .underflow_err(underflow_err), .rate_err(rate_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called on the sample where de rises at a frame start; returns on the next one
  task automatic measure(output int flen, output int dcnt, output int lines, output int lper,
                         output int badrun, output int acc, output int re);
    int low, hi, k0;
    logic prev;
    re = int'(rate_err); k0 = k;
    flen = 1; dcnt = 1; lines = 1; lper = 0; badrun = 0; low = 0; hi = 1; prev = 1;
    forever begin
      @(negedge clk);
      if (de) begin
        if (!prev && low > HB_MAX) break;
        if (!prev) begin
          lines++;
          if (lper == 0) lper = flen;
          hi = 1;
        end else hi++;
        dcnt++;
      end else begin
        if (prev) begin
          if (hi != H_ACT) badrun++;
          low = 0;
        end
        low++;
      end
      prev = de;
      flen++;
    end
    acc = k - k0;
  endtask

  task automatic wait_start();
    int low = 0;
    logic prev = de;
    forever begin
      @(negedge clk);
      if (de && !prev && low > HB_MAX) break;
      if (!de) begin
        if (prev) low = 0;
        low++;
      end
      prev = de;
    end
  endtask

  initial begin
    #(T_CLK * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int flen, dcnt, lines, lper, badrun, acc, re, prevf;
    repeat (3) @(negedge clk);
    check(de == 0, "R1 de in reset", int'(de), 0);
    check(odd_rgb == 0 && even_rgb == 0, "R1 buses in reset", int'(odd_rgb), 0);
    check(underflow_err == 0, "R1 underflow_err in reset", int'(underflow_err), 0);
    check(rate_err == 0, "R1 rate_err in reset", int'(rate_err), 0);
    rst = 0;
    @(negedge clk);
    check(de == 0, "R1 de after first edge", int'(de), 0);
    @(negedge clk);
    check(de == 1, "R1 de after second edge", int'(de), 1);
    mon_en = 1;
    measure(flen, dcnt, lines, lper, badrun, acc, re);
    check(flen == 42, "R3 default frame length", flen, 42);
    check(lper == 7, "R2 default line period", lper, 7);
    prevf = 42;

    for (int v = 0; v < NVEC; v++) begin
      hblank_cfg = 8'(VEC[v][0]);
      vblank_cfg = 8'(VEC[v][1]);
      mode_50hz  = VEC[v][2][0];
      pix_bad = 0;
      measure(flen, dcnt, lines, lper, badrun, acc, re);
      check(flen == prevf, "R5 frame in progress keeps old length", flen, prevf);
      measure(flen, dcnt, lines, lper, badrun, acc, re);
      check(flen == VEC[v][4], "R3 frame length", flen, VEC[v][4]);
      check(lper == VEC[v][3], "R2/R4 line period", lper, VEC[v][3]);
      check(badrun == 0, "R2 de run of H_ACT clocks", badrun, 0);
      check(lines == V_ACT, "R3 active lines", lines, V_ACT);
      check(dcnt == H_ACT * V_ACT, "R3 de clocks per frame", dcnt, H_ACT * V_ACT);
      check(acc == H_ACT * V_ACT, "R6 pairs consumed per frame", acc, H_ACT * V_ACT);
      check(re == VEC[v][5], "R8 rate_err", re, VEC[v][5]);
      check(pix_bad == 0, "R6 pair order odd/even", bad_act, bad_exp);
      prevf = VEC[v][4];
    end

    // underflow in the middle of the first line of a frame
    mon_en = 0;
    check(underflow_err == 0, "R7 no underflow before starving", int'(underflow_err), 0);
    pix_valid = 0;
    @(negedge clk);
    check(de == 1, "R7 de kept during underflow", int'(de), 1);
    check(odd_rgb == 0 && even_rgb == 0, "R7 black during underflow", int'(odd_rgb), 0);
    check(underflow_err == 1, "R7 underflow_err set", int'(underflow_err), 1);
    @(negedge clk);
    pix_valid = 1;
    wait_start();
    check(underflow_err == 1, "R7 underflow_err sticky", int'(underflow_err), 1);
    pix_bad = 0;
    mon_en = 1;
    measure(flen, dcnt, lines, lper, badrun, acc, re);
    check(pix_bad == 0, "R6 pairs resume after underflow", bad_act, bad_exp);
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    check(underflow_err == 0, "R7 underflow_err cleared by reset", int'(underflow_err), 0);
    check(de == 0 && rate_err == 0, "R1 outputs cleared by reset", int'(de), 0);
    rst = 0;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule